// File: doc/BRIEF.md
# Indirect Coefficient Access Port

This block holds a bank of 120 coefficients, each 32 bits wide, that an adaptive echo canceller uses, and lets a byte-wide host bus reach them indirectly. The host never addresses a coefficient directly. It works through a 32-bit staging register, seen as four byte locations, and through two 7-bit index registers. One index register fetches a coefficient and the other commits one.

To read a coefficient, the host writes its index to the fetch index register. It then waits for the transfer to finish and reads the four staging bytes. To change a coefficient, the host fills the four staging bytes first and then writes the index to the commit index register. Both kinds of transfer are deferred to the line's symbol strobe. Each one completes on the second strobe after the index write. A busy output covers the whole wait, and a sticky error output flags an index that is out of range.

Top module: `coef_access_port`

## Requirements
- R1: After reset, the staging register, both index registers and every coefficient read as zero, and busy and sel_err are both low.
- R2: The host reaches six locations. Addresses 0 to 3 are the staging bytes. Address 4 is the fetch index register and address 5 is the commit index register. Each index register takes bits 6:0 of host_wdata and reads back its last accepted value with bit 7 as zero. Any other address reads as zero.
- R3: Writing a valid index to address 4 sets busy. On the second sym_strobe clock edge after that write, the staging register takes the selected coefficient and busy drops on that same edge.
- R4: A fetch transfer never changes any coefficient.
- R5: Writing a valid index to address 5 sets busy. On the second sym_strobe clock edge after that write, the selected coefficient takes all 32 bits of the staging register and busy drops on that same edge.
- R6: A commit transfer leaves the staging register unchanged.
- R7: Staging byte address k (0 to 3) holds bits 8k+7 down to 8k of the 32-bit value, so address 0 is the least significant byte.
- R8: An index write of 120 or more to address 4 or 5 is ignored: the index register keeps its value and no transfer starts. It also sets sel_err, which stays high until reset.
- R9: An index write to address 4 or 5 while busy is high is ignored: the index register keeps its value and the pending transfer goes on unchanged.
- R10: A sym_strobe in the same cycle as the index write does not count. Busy stays high through the first later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_strobe | input | 1 | One-cycle pulse per symbol period |
| host_wr | input | 1 | Host write enable for this cycle |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from host_addr |
| busy | output | 1 | A fetch or commit transfer is pending |
| sel_err | output | 1 | Sticky flag for an out-of-range index write |

## Verification
A strobe counter that is off by one makes busy drop one symbol too early or too late. That shows at the busy pin within two strobes of the index write. If the pending direction or index is latched wrong, the error stays hidden until the host fetches that coefficient back. It then shows as wrong staging bytes, or as a staging register that a commit has overwritten. Corruption in the bank only appears when the damaged entry is next fetched, so the stimulus keeps fetching entries it committed earlier.

// File: rtl/coef_pkg.sv
package coef_pkg;
    typedef enum logic {
        XFER_FETCH  = 1'b0,
        XFER_COMMIT = 1'b1
    } xfer_dir_e;

    localparam logic [2:0] ADDR_FETCH_SEL  = 3'd4;
    localparam logic [2:0] ADDR_COMMIT_SEL = 3'd5;
endpackage

// File: rtl/coef_bank.sv
module coef_bank #(
    parameter int N_TAPS = 120,
    parameter int COEF_W = 32,
    localparam int IDX_W = $clog2(N_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [COEF_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [COEF_W-1:0] wr_data
);
    logic [COEF_W-1:0] mem_q [N_TAPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_TAPS; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

    // R5
    wr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import coef_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  xfer_dir_e        start_dir,
    input  logic [IDX_W-1:0] start_idx,
    input  logic             strobe,
    output logic             busy,
    output logic             fire,
    output xfer_dir_e        fire_dir,
    output logic [IDX_W-1:0] fire_idx
);
    typedef struct packed {
        logic             busy;
        logic             seen;
        xfer_dir_e        dir;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (st_q.busy && strobe) begin
            if (st_q.seen) begin
                fire       = 1'b1;
                st_d.busy  = 1'b0;
                st_d.seen  = 1'b0;
            end else begin
                st_d.seen  = 1'b1;
            end
        end else if (!st_q.busy && start) begin
            st_d.busy = 1'b1;
            st_d.seen = 1'b0;
            st_d.dir  = start_dir;
            st_d.idx  = start_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign fire_dir = st_q.dir;
    assign fire_idx = st_q.idx;

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !strobe) |=> st_q.busy);

    // R9
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !fire) |=> ($stable(st_q.idx) && $stable(st_q.dir)));
endmodule

// File: rtl/coef_access_port.sv
module coef_access_port
    import coef_pkg::*;
#(
    parameter int N_TAPS = 120,
    parameter int COEF_W = 32,
    localparam int IDX_W  = $clog2(N_TAPS),
    localparam int NBYTES = COEF_W / 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sym_strobe,
    input  logic       host_wr,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       busy,
    output logic       sel_err
);
    typedef struct packed {
        logic [COEF_W-1:0] data;
        logic [IDX_W-1:0]  fsel;
        logic [IDX_W-1:0]  csel;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic              seq_start, seq_fire;
    xfer_dir_e         start_dir, fire_dir;
    logic [IDX_W-1:0]  wr_idx, fire_idx;
    logic [COEF_W-1:0] bank_rdata;
    logic              bank_we;
    logic              sel_wr_f, sel_wr_c, idx_ok, data_wr;

    assign wr_idx    = host_wdata[IDX_W-1:0];
    assign idx_ok    = (wr_idx < IDX_W'(N_TAPS));
    assign sel_wr_f  = host_wr && (host_addr == ADDR_FETCH_SEL);
    assign sel_wr_c  = host_wr && (host_addr == ADDR_COMMIT_SEL);
    assign data_wr   = host_wr && (32'(host_addr) < NBYTES);
    assign seq_start = (sel_wr_f || sel_wr_c) && idx_ok && !busy;
    assign start_dir = sel_wr_c ? XFER_COMMIT : XFER_FETCH;
    assign bank_we   = seq_fire && (fire_dir == XFER_COMMIT);

    always_comb begin
        r_d = r_q;
        if (data_wr) r_d.data[8*host_addr +: 8] = host_wdata;
        if ((sel_wr_f || sel_wr_c) && !idx_ok) r_d.err = 1'b1;
        if (seq_start && sel_wr_f) r_d.fsel = wr_idx;
        if (seq_start && sel_wr_c) r_d.csel = wr_idx;
        if (seq_fire && fire_dir == XFER_FETCH) r_d.data = bank_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        host_rdata = '0;
        if (32'(host_addr) < NBYTES)          host_rdata = r_q.data[8*host_addr +: 8];
        else if (host_addr == ADDR_FETCH_SEL)  host_rdata = 8'(r_q.fsel);
        else if (host_addr == ADDR_COMMIT_SEL) host_rdata = 8'(r_q.csel);
    end

    assign sel_err = r_q.err;

    xfer_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (seq_start),
        .start_dir (start_dir),
        .start_idx (wr_idx),
        .strobe    (sym_strobe),
        .busy      (busy),
        .fire      (seq_fire),
        .fire_dir  (fire_dir),
        .fire_idx  (fire_idx)
    );

    coef_bank #(.N_TAPS(N_TAPS), .COEF_W(COEF_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (fire_idx),
        .rd_data (bank_rdata),
        .wr_en   (bank_we),
        .wr_idx  (fire_idx),
        .wr_data (r_q.data)
    );

    // R3
    fetch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fire && fire_dir == XFER_FETCH) |=> r_q.data == $past(bank_rdata));

    // R6
    commit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_fire && fire_dir == XFER_COMMIT && !data_wr) |=> $stable(r_q.data));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err |=> r_q.err);

    // R8
    bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_wr_f || sel_wr_c) && !idx_ok) |=> (r_q.err && $stable(r_q.fsel) && $stable(r_q.csel)));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (sel_wr_f || sel_wr_c)) |=> ($stable(r_q.fsel) && $stable(r_q.csel)));
endmodule

// File: tb/coef_access_port_tb.sv
module coef_access_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_strobe = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       busy, sel_err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] ref_coef [120];
    logic [31:0] ref_data;
    logic [6:0]  ref_fsel, ref_csel;

    always #10 clk = ~clk;

    coef_access_port u_dut (
        .clk(clk), .rst_n(rst_n), .sym_strobe(sym_strobe), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .sel_err(sel_err)
    );

    function automatic logic [7:0] byte_of(logic [31:0] v, int k);
        return v[8*k +: 8];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic host_write(logic [2:0] a, logic [7:0] d, logic strb = 1'b0);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d; sym_strobe = strb;
        @(negedge clk);
        host_wr = 1'b0; sym_strobe = 1'b0;
    endtask

    task automatic host_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic read_data(output logic [31:0] v);
        logic [7:0] b;
        for (int k = 0; k < 4; k++) begin
            host_read(3'(k), b);
            v[8*k +: 8] = b;
        end
    endtask

    task automatic strobe_once();
        @(negedge clk);
        sym_strobe = 1'b1;
        @(negedge clk);
        sym_strobe = 1'b0;
    endtask

    task automatic fill_data(logic [31:0] v);
        for (int k = 0; k < 4; k++) host_write(3'(k), byte_of(v, k));
        ref_data = v;
    endtask

    task automatic commit(logic [6:0] idx, string tag);
        logic [31:0] got;
        host_write(3'd5, {1'b0, idx});
        ref_csel = idx;
        check({tag, " busy after commit select"}, 32'(busy), 32'd1);
        strobe_once();
        check({tag, " busy after first strobe"}, 32'(busy), 32'd1);
        strobe_once();
        check({tag, " busy after second strobe"}, 32'(busy), 32'd0);
        ref_coef[idx] = ref_data;
        read_data(got);
        check("R6 staging kept by commit", got, ref_data);
    endtask

    task automatic fetch(logic [6:0] idx, string tag);
        logic [31:0] got;
        host_write(3'd4, {1'b0, idx});
        ref_fsel = idx;
        check({tag, " busy after fetch select"}, 32'(busy), 32'd1);
        strobe_once();
        strobe_once();
        check({tag, " busy clear after fetch"}, 32'(busy), 32'd0);
        ref_data = ref_coef[idx];
        read_data(got);
        check("R3 R7 fetched value", got, ref_data);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  b;
        void'($urandom(32'd7331));
        for (int i = 0; i < 120; i++) ref_coef[i] = '0;
        ref_data = '0; ref_fsel = '0; ref_csel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_data(v);
        check("R1 staging reset", v, 32'd0);
        host_read(3'd4, b); check("R1 fetch index reset", 32'(b), 0);
        host_read(3'd5, b); check("R1 commit index reset", 32'(b), 0);
        check("R1 busy reset", 32'(busy), 0);
        check("R1 err reset", 32'(sel_err), 0);
        fetch(7'd119, "R1");

        // R7 byte lanes
        fill_data(32'hA1B2C3D4);
        host_read(3'd0, b); check("R7 byte 0", 32'(b), 32'hD4);
        host_read(3'd3, b); check("R7 byte 3", 32'(b), 32'hA1);
        host_read(3'd6, b); check("R2 unmapped address", 32'(b), 0);

        // R5 commit then fetch back; R4 fetch twice
        commit(7'd0, "R5");
        commit(7'd119, "R5");
        fill_data(32'h0);
        fetch(7'd119, "R3");
        fetch(7'd119, "R4");
        host_read(3'd4, b); check("R2 fetch index readback", 32'(b), 32'(ref_fsel));
        host_read(3'd5, b); check("R2 commit index readback", 32'(b), 32'(ref_csel));

        // R10 strobe in the same cycle as the select write is not counted
        host_write(3'd4, 8'd0, 1'b1);
        check("R10 busy set", 32'(busy), 1);
        strobe_once();
        check("R10 busy after one later strobe", 32'(busy), 1);
        strobe_once();
        check("R10 busy after two later strobes", 32'(busy), 0);
        read_data(v); ref_data = ref_coef[0];
        check("R10 fetched value", v, ref_data);
        ref_fsel = 7'd0;

        // R9 select write while busy is ignored
        host_write(3'd4, 8'd119);
        host_write(3'd5, 8'd5);
        host_write(3'd4, 8'd7);
        host_read(3'd5, b); check("R9 commit index unchanged", 32'(b), 32'(ref_csel));
        host_read(3'd4, b); check("R9 fetch index from first write", 32'(b), 32'd119);
        check("R9 still busy", 32'(busy), 1);
        strobe_once(); strobe_once();
        read_data(v); ref_data = ref_coef[119];
        check("R9 pending transfer unchanged", v, ref_data);
        ref_fsel = 7'd119;
        check("R9 no error", 32'(sel_err), 0);

        // R8 out-of-range index
        host_write(3'd4, 8'd120);
        check("R8 no transfer", 32'(busy), 0);
        check("R8 err set", 32'(sel_err), 1);
        host_read(3'd4, b); check("R8 fetch index kept", 32'(b), 32'(ref_fsel));
        host_write(3'd5, 8'd127);
        host_read(3'd5, b); check("R8 commit index kept", 32'(b), 32'(ref_csel));
        fetch(7'd3, "R8");
        check("R8 err sticky", 32'(sel_err), 1);

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [6:0] idx;
            idx = 7'($urandom_range(0, 119));
            if ($urandom_range(0, 1) == 1) begin
                fill_data($urandom);
                commit(idx, "R5");
            end else begin
                fetch(idx, "R3");
            end
        end
        for (int i = 0; i < 120; i += 17) fetch(7'(i), "R4");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule